// File: doc/BRIEF.md
# Flash Ready and Status Poller

This block waits for an external flash device to finish an erase or program operation. A caller pulses `start` with the polling method, the address to poll and a timeout count. The block then reads the device through a simple single-beat read master port, one poll per tick interval. When it has a verdict it pulses `done` for one cycle and presents a result code that stays valid until the next accepted start.

Two completion methods are supported. In status-register mode one word is read per poll. The operation is complete once the ready bit is set, and only then are the error bits decoded, in a fixed priority. In toggle mode two reads are made back to back in each poll, and the operation is complete once bit 6 agrees between them. The timeout count is scaled by ten into a budget of polls. A built-in prescaler of `TICK_CYCLES` clocks spaces the polls apart.

Top module: `flash_poller`

## Requirements
- R1: After reset `done` and `rdReq` are low and `result` is 0.
- R2: An accepted start loads a budget of `timeout`×10 polls. Each poll begins after a wait of `TICK_CYCLES` clocks. A timeout of 0 finishes at once with result 5 and makes no read.
- R3: In status mode (`pollMode`=0) each poll issues one read at the latched `statAddr`. The poll is complete when bit 7 of the returned word is 1.
- R4: In status mode, bit 0, bit 7 and every bit above 7 play no part in the error decode. A ready word with no other bit in 6..1 set gives result 0.
- R5: Error priority on a ready status word is as follows. Bit 1 gives result 1. Otherwise bit 4 gives result 2. Otherwise bit 5 gives result 3. Otherwise any of bits 6, 3 or 2 gives result 4.
- R6: In toggle mode (`pollMode`=1) each poll issues two reads. The poll is complete with result 0 when bit 6 is equal in both words. Other bits are not decoded.
- R7: If the budget runs out without completion, the result is 5.
- R8: `done` is high for exactly one cycle. `result` holds its value until the next accepted start.
- R9: A `start` pulse while an operation is in progress is ignored. Address, mode, budget and outcome are unchanged.
- R10: With a read answered in the cycle after `rdReq`, an operation that ends after N polls raises `done` N×(TICK_CYCLES+3) cycles after the start edge in status mode, or N×(TICK_CYCLES+5) cycles in toggle mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse that begins a wait |
| pollMode | input | 1 | 0 = status-register polling, 1 = toggle polling |
| statAddr | input | ADDR_W | Address to poll |
| timeout | input | TO_W | Timeout count, scaled by 10 into polls |
| rdReq | output | 1 | One-cycle read request |
| rdAddr | output | ADDR_W | Read address |
| rdValid | input | 1 | Read data valid |
| rdData | input | DATA_W | Read data |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 protect, 2 program, 3 erase, 4 other, 5 timeout |

## Verification
The bench responds to every read request in the following cycle. The `done` pulse is therefore due a fixed number of cycles after the start edge: the number of polls times TICK_CYCLES+3 in status mode, or TICK_CYCLES+5 in toggle mode, and zero polls for a zero timeout. The bench predicts the poll count and the read count from the data words it queues. It then walks the run one clock at a time, sampling on the falling edge, and records the exact cycle in which `done` rises. It compares that cycle, the result, the number of reads and the address of each read against its prediction. It also checks that `done` has dropped one cycle later and that `result` still holds several cycles after that.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_PROTECT = 3'd1,
    RES_PROGRAM = 3'd2,
    RES_ERASE   = 3'd3,
    RES_OTHER   = 3'd4,
    RES_TIMEOUT = 3'd5
  } result_e;

  typedef struct packed {
    logic latch;
    logic cap1;
    logic cap2;
    logic setRes;
    logic setTo;
  } strobe_t;

  localparam int READY_BIT   = 7;
  localparam int ERASE_BIT   = 5;
  localparam int PROG_BIT    = 4;
  localparam int PROTECT_BIT = 1;
  localparam int TOGGLE_BIT  = 6;
endpackage

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import poll_pkg::*;
#(
  parameter int TO_W        = 16,
  parameter int TICK_CYCLES = 5000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            pollMode,
  input  logic [TO_W-1:0] timeout,
  input  logic            rdValid,
  input  logic            complete,
  output logic            modeQ,
  output logic            rdReq,
  output logic            done,
  output strobe_t         strb
);
  localparam int BUD_W  = TO_W + 4;
  localparam int TICK_W = $clog2(TICK_CYCLES + 1);
  localparam logic [BUD_W-1:0]  SCALE    = BUD_W'(10);
  localparam logic [TICK_W-1:0] TICK_END = TICK_W'(TICK_CYCLES - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_ISS1, S_RSP1, S_ISS2, S_RSP2, S_EVAL, S_DONE
  } state_e;

  state_e            state, stateNxt;
  logic [BUD_W-1:0]  budget;
  logic [TICK_W-1:0] tickCnt;
  logic              pastValid;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    case (state)
      S_IDLE: if (start) begin
        strb.latch = 1'b1;
        if (timeout == '0) begin
          strb.setTo = 1'b1;
          stateNxt   = S_DONE;
        end else begin
          stateNxt = S_WAIT;
        end
      end
      S_WAIT: if (tickCnt == TICK_END) stateNxt = S_ISS1;
      S_ISS1: stateNxt = S_RSP1;
      S_RSP1: if (rdValid) begin
        strb.cap1 = 1'b1;
        stateNxt  = modeQ ? S_ISS2 : S_EVAL;
      end
      S_ISS2: stateNxt = S_RSP2;
      S_RSP2: if (rdValid) begin
        strb.cap2 = 1'b1;
        stateNxt  = S_EVAL;
      end
      S_EVAL: begin
        if (complete) begin
          strb.setRes = 1'b1;
          stateNxt    = S_DONE;
        end else if (budget == '0) begin
          strb.setTo = 1'b1;
          stateNxt   = S_DONE;
        end else begin
          stateNxt = S_WAIT;
        end
      end
      S_DONE:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      budget    <= '0;
      tickCnt   <= '0;
      modeQ     <= 1'b0;
      pastValid <= 1'b0;
    end else begin
      state     <= stateNxt;
      pastValid <= 1'b1;
      if (strb.latch) begin
        budget  <= BUD_W'(timeout) * SCALE;
        modeQ   <= pollMode;
        tickCnt <= '0;
      end else if (state == S_WAIT) begin
        if (tickCnt == TICK_END) begin
          tickCnt <= '0;
          budget  <= budget - 1'b1;
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
    end
  end

  assign rdReq = (state == S_ISS1) || (state == S_ISS2);
  assign done  = (state == S_DONE);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rdReq |=> !rdReq);
  // R9
  budget_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (pastValid && state != S_IDLE && $past(state) != S_IDLE) |-> budget <= $past(budget));
  // R2
  zero_to_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start && timeout == '0) |=> done);
endmodule

// File: rtl/poll_dp.sv
module poll_dp
  import poll_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic              modeQ,
  input  logic [ADDR_W-1:0] statAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              complete,
  output logic [2:0]        result
);
  logic [DATA_W-1:0] word1, word2;
  logic [DATA_W-1:0] errBits;
  result_e           resultQ, statCode;

  always_comb begin
    errBits = '0;
    for (int b = 1; b < READY_BIT; b++) errBits[b] = word1[b];
    if (errBits[PROTECT_BIT])   statCode = RES_PROTECT;
    else if (errBits[PROG_BIT]) statCode = RES_PROGRAM;
    else if (errBits[ERASE_BIT]) statCode = RES_ERASE;
    else if (errBits != '0)     statCode = RES_OTHER;
    else                        statCode = RES_OK;
  end

  assign complete = modeQ ? (word1[TOGGLE_BIT] == word2[TOGGLE_BIT])
                          : word1[READY_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdAddr  <= '0;
      word1   <= '0;
      word2   <= '0;
      resultQ <= RES_OK;
    end else begin
      if (strb.latch) rdAddr <= statAddr;
      if (strb.cap1)  word1  <= rdData;
      if (strb.cap2)  word2  <= rdData;
      if (strb.setTo)       resultQ <= RES_TIMEOUT;
      else if (strb.setRes) resultQ <= modeQ ? RES_OK : statCode;
      else if (strb.latch)  resultQ <= RES_OK;
    end
  end

  assign result = resultQ;

  // R6
  toggle_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.setRes && modeQ) |=> result == RES_OK);
  // R7
  timeout_code_chk: assert property (@(posedge clk) disable iff (rst)
    strb.setTo |=> result == RES_TIMEOUT);
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(strb.latch || strb.setRes || strb.setTo) |=> $stable(result));
endmodule

// File: rtl/flash_poller.sv
module flash_poller
  import poll_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int TO_W        = 16,
  parameter int TICK_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pollMode,
  input  logic [ADDR_W-1:0] statAddr,
  input  logic [TO_W-1:0]   timeout,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic [2:0]        result
);
  strobe_t strb;
  logic    modeQ;
  logic    complete;

  poll_ctrl #(.TO_W(TO_W), .TICK_CYCLES(TICK_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .pollMode(pollMode),
    .timeout(timeout), .rdValid(rdValid), .complete(complete),
    .modeQ(modeQ), .rdReq(rdReq), .done(done), .strb(strb)
  );

  poll_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .modeQ(modeQ),
    .statAddr(statAddr), .rdData(rdData), .rdAddr(rdAddr),
    .complete(complete), .result(result)
  );
endmodule

// File: tb/flash_poller_bench.sv
module flash_poller_bench;
  localparam int T = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        pollMode = 1'b0;
  logic [23:0] statAddr = '0;
  logic [15:0] timeout = '0;
  logic        rdReq;
  logic [23:0] rdAddr;
  logic        rdValid = 1'b0;
  logic [15:0] rdData = '0;
  logic        done;
  logic [2:0]  result;

  int checks = 0;
  int fails = 0;
  int readCount = 0;
  logic [15:0] rdQueue[$];
  logic [15:0] fillWord = '0;
  bit          altFill = 1'b0;
  logic [23:0] expAddr = '0;

  always #10 clk = ~clk;

  flash_poller #(.ADDR_W(24), .DATA_W(16), .TO_W(16), .TICK_CYCLES(T)) u_flash_poller (
    .clk(clk), .rst(rst), .start(start), .pollMode(pollMode),
    .statAddr(statAddr), .timeout(timeout), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdData(rdData), .done(done), .result(result)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Read responder: answers each request in the following cycle.
  initial begin
    bit pending = 1'b0;
    forever begin
      @(negedge clk);
      rdValid = 1'b0;
      if (pending) begin
        rdValid = 1'b1;
        if (rdQueue.size() > 0) rdData = rdQueue.pop_front();
        else rdData = fillWord ^ ((altFill && readCount[0]) ? 16'h0040 : 16'h0000);
        readCount++;
        pending = 1'b0;
      end
      if (rdReq) begin
        pending = 1'b1;
        // R3: read goes to the latched status address
        check(rdAddr == expAddr, "R3 addr", int'(rdAddr), int'(expAddr));
      end
    end
  end

  task automatic runOp(input bit tg, input logic [15:0] to, input logic [23:0] adr,
                       input int expN, input int expRes, input int expReads,
                       input int injectAt, input string tag);
    int doneAt;
    int reads0;
    int per;
    per = tg ? T + 5 : T + 3;
    expAddr = adr;
    @(negedge clk);
    reads0 = readCount;
    pollMode = tg; timeout = to; statAddr = adr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    doneAt = -1;
    for (int c = 0; c < 3000 && doneAt < 0; c++) begin
      if (done) doneAt = c;
      else begin
        if (c == injectAt) begin
          start = 1'b1; pollMode = ~tg; timeout = 16'd0; statAddr = adr ^ 24'h5A5A5A;
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
      end
    end
    start = 1'b0;
    // R10: done due after expN polls of per cycles each
    check(doneAt == expN * per, {"R10 done cycle ", tag}, doneAt, expN * per);
    check(int'(result) == expRes, {"result ", tag}, int'(result), expRes);
    check(readCount - reads0 == expReads, {"read count ", tag}, readCount - reads0, expReads);
    @(negedge clk);
    // R8: single-cycle done
    check(done == 1'b0, {"R8 done pulse ", tag}, int'(done), 0);
    repeat (4) @(negedge clk);
    // R8: result held
    check(int'(result) == expRes, {"R8 result hold ", tag}, int'(result), expRes);
    rdQueue.delete();
    fillWord = '0;
    altFill = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(rdReq == 1'b0, "R1 rdReq", int'(rdReq), 0);
    check(result == 3'd0, "R1 result", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && rdReq == 1'b0, "R1 idle", int'(done), 0);

    // R3: ready on first poll
    rdQueue.push_back(16'h0080);
    runOp(1'b0, 16'd1, 24'h001234, 1, 0, 1, -1, "R3 ready");

    // R4: not ready twice, then ready with reserved bits set
    rdQueue.push_back(16'h0000); rdQueue.push_back(16'h0040); rdQueue.push_back(16'hFF81);
    runOp(1'b0, 16'd1, 24'h00ABCD, 3, 0, 3, -1, "R4 mask");

    // R5: error priority
    rdQueue.push_back(16'h00B2);
    runOp(1'b0, 16'd1, 24'h000010, 1, 1, 1, -1, "R5 protect");
    rdQueue.push_back(16'h00F0);
    runOp(1'b0, 16'd1, 24'h000020, 1, 2, 1, -1, "R5 program");
    rdQueue.push_back(16'h00A8);
    runOp(1'b0, 16'd1, 24'h000030, 1, 3, 1, -1, "R5 erase");
    rdQueue.push_back(16'h0084);
    runOp(1'b0, 16'd1, 24'h000040, 1, 4, 1, -1, "R5 other bit2");
    rdQueue.push_back(16'h00C1);
    runOp(1'b0, 16'd1, 24'h000050, 1, 4, 1, -1, "R5 other bit6");

    // R7: budget of 10 polls exhausted
    runOp(1'b0, 16'd1, 24'h000060, 10, 5, 10, -1, "R7 status timeout");

    // R2: zero timeout finishes at once without reads
    runOp(1'b0, 16'd0, 24'h000070, 0, 5, 0, -1, "R2 zero");

    // R2: timeout 2 gives 20 polls, ready at poll 15
    for (int i = 0; i < 14; i++) rdQueue.push_back(16'h0000);
    rdQueue.push_back(16'h0080);
    runOp(1'b0, 16'd2, 24'h000080, 15, 0, 15, -1, "R2 scaled budget");

    // R6: toggle, bit 6 differs twice then agrees
    rdQueue.push_back(16'h0040); rdQueue.push_back(16'h0000);
    rdQueue.push_back(16'h0000); rdQueue.push_back(16'h0040);
    rdQueue.push_back(16'h0042); rdQueue.push_back(16'h0046);
    runOp(1'b1, 16'd1, 24'h000090, 3, 0, 6, -1, "R6 toggle");

    // R6/R7: toggle never settles
    altFill = 1'b1; fillWord = 16'h0002;
    runOp(1'b1, 16'd1, 24'h0000A0, 10, 5, 20, -1, "R6 toggle timeout");

    // R9: start while busy is ignored
    runOp(1'b0, 16'd1, 24'h0000B0, 10, 5, 10, 20, "R9 busy start");
    rdQueue.push_back(16'h0000); rdQueue.push_back(16'h0090);
    runOp(1'b0, 16'd1, 24'h0000C0, 2, 2, 2, 9, "R9 busy start status");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule